// File: doc/BRIEF.md
# Motion History Image Updater

This block updates a motion-history frame, one pixel per beat. Each beat carries the current-frame pixel, the previous-frame pixel and the history value stored for that pixel. The block takes the absolute difference of the two frame pixels and compares it against a threshold to decide whether the pixel is moving. A moving pixel has its history set to the ceiling value of 255. A still pixel has its history lowered by one, and the value stops at zero. The new value goes out together with a write address, so the history frame in memory can be rewritten in place. A motion-energy bit is also produced. It is high whenever the new history value is non-zero.

The caller gives each run a segment: a base address and a pixel count. It then streams that many pixels in raster order. Several instances can each be handed a disjoint slice of the frame and run in parallel. Because the slices do not overlap, no instance reads a history location that another instance is writing. The threshold is captured when the segment starts. A done pulse reports that the last write of the segment has been issued.

Top module: `mhi_updater`

## Requirements
- R1: While rst_ni is low and in the first cycle after its release, out_valid_o, done_o and in_ready_o are all 0.
- R2: start_i sampled high while the unit is idle with a non-zero seg_len_i latches seg_base_i, seg_len_i and thresh_i, and in_ready_o is 1 from the next cycle. start_i is ignored while a segment is active. A start with seg_len_i equal to 0 is ignored: in_ready_o stays 0 and no done_o follows.
- R3: A pixel is moving when |cur_pix_i - prev_pix_i| is strictly greater than the latched threshold. In either operand order, a moving pixel yields new_hist_o = 255 and energy_o = 1. A difference equal to the threshold is not motion.
- R4: For a pixel that is not moving, new_hist_o = old_hist_i - 1, or 0 when old_hist_i is 0.
- R5: energy_o is 1 exactly when new_hist_o is non-zero.
- R6: A beat is accepted when in_valid_i and in_ready_o are both 1 at a rising edge. Its result appears with out_valid_o = 1 in the following cycle, and only then. Results come out in acceptance order, with out_addr_o = segment base + index of the pixel within the segment.
- R7: in_ready_o falls in the cycle after the segment's final pixel is accepted. Further beats offered with in_valid_i = 1 produce no output.
- R8: done_o is a single-cycle pulse, raised in the cycle right after the output beat of the segment's final pixel.
- R9: Changing thresh_i while a segment is active has no effect on that segment's results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a segment (honoured only when idle) |
| seg_base_i | input | ADDR_W | First history address of the segment |
| seg_len_i | input | ADDR_W | Number of pixels in the segment |
| thresh_i | input | 8 | Motion threshold, latched at start |
| in_valid_i | input | 1 | Input beat valid |
| in_ready_o | output | 1 | Unit accepts a beat this cycle |
| cur_pix_i | input | 8 | Current-frame pixel |
| prev_pix_i | input | 8 | Previous-frame pixel |
| old_hist_i | input | 8 | Stored history value of the pixel |
| out_valid_o | output | 1 | History write beat valid |
| out_addr_o | output | ADDR_W | Write address of the new history value |
| new_hist_o | output | 8 | Updated history value |
| energy_o | output | 1 | Motion-energy bit (new history non-zero) |
| done_o | output | 1 | Segment completion pulse |

## Verification
On every cycle the assertions check the following. Each output beat follows an accepted input by one cycle. A non-saturated result is exactly the decayed old value of the beat that produced it. The energy bit agrees with the history value. done_o is a single-cycle pulse that trails a write beat. The scoreboard bench covers what a property cannot express without copying the datapath. That includes the thresholded difference in both operand orders and at the exact threshold, and addresses counted from the segment base. It also covers a start or threshold change that arrives mid-segment and is ignored, refusal of beats once the segment is complete, and rejection of a zero-length start.

// File: rtl/mhi_pkg.sv
package mhi_pkg;
  localparam int PIX_W = 8;

  typedef logic [PIX_W-1:0] pix_t;

  typedef struct packed {
    pix_t hist;
    logic energy;
  } hist_res_t;
endpackage

// File: rtl/mhi_motion_detect.sv
module mhi_motion_detect
  import mhi_pkg::*;
(
  input  pix_t cur_i,
  input  pix_t prev_i,
  input  pix_t thresh_i,
  output logic moving_o
);
  pix_t diff;

  always_comb begin
    diff     = (cur_i >= prev_i) ? (cur_i - prev_i) : (prev_i - cur_i);
    moving_o = diff > thresh_i;
  end
endmodule

// File: rtl/mhi_hist_update.sv
module mhi_hist_update
  import mhi_pkg::*;
#(
  parameter int HIST_MAX = 255
) (
  input  logic      moving_i,
  input  pix_t      old_i,
  output hist_res_t res_o
);
  localparam pix_t Ceiling = pix_t'(HIST_MAX);

  always_comb begin
    if (moving_i)           res_o.hist = Ceiling;
    else if (old_i == '0)   res_o.hist = '0;
    else                    res_o.hist = old_i - pix_t'(1);
    res_o.energy = res_o.hist != '0;
  end
endmodule

// File: rtl/mhi_seg_ctrl.sv
module mhi_seg_ctrl #(
  parameter int ADDR_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W-1:0] len_i,
  input  logic              accept_i,
  output logic              active_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              last_o
);
  logic              active_q;
  logic [ADDR_W-1:0] base_q, len_q, cnt_q;

  assign active_o = active_q;
  assign addr_o   = base_q + cnt_q;
  assign last_o   = cnt_q == (len_q - ADDR_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      base_q   <= '0;
      len_q    <= '0;
      cnt_q    <= '0;
    end else if (load_i) begin
      active_q <= 1'b1;
      base_q   <= base_i;
      len_q    <= len_i;
      cnt_q    <= '0;
    end else if (accept_i) begin
      cnt_q <= cnt_q + ADDR_W'(1);
      if (last_o) active_q <= 1'b0;
    end
  end
endmodule

// File: rtl/mhi_updater.sv
module mhi_updater
  import mhi_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int HIST_MAX = 255
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] seg_base_i,
  input  logic [ADDR_W-1:0] seg_len_i,
  input  logic [7:0]        thresh_i,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [7:0]        cur_pix_i,
  input  logic [7:0]        prev_pix_i,
  input  logic [7:0]        old_hist_i,
  output logic              out_valid_o,
  output logic [ADDR_W-1:0] out_addr_o,
  output logic [7:0]        new_hist_o,
  output logic              energy_o,
  output logic              done_o
);
  logic              active, accept, load, last, moving;
  logic [ADDR_W-1:0] addr;
  pix_t              thr_q;
  hist_res_t         res;

  logic              out_valid_q, energy_q, last_q, done_q;
  logic [ADDR_W-1:0] addr_q;
  pix_t              hist_q;

  assign load       = start_i && !active && (seg_len_i != '0);
  assign accept     = in_valid_i && active;
  assign in_ready_o = active;

  mhi_seg_ctrl #(.ADDR_W(ADDR_W)) i_seg_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (load),
    .base_i   (seg_base_i),
    .len_i    (seg_len_i),
    .accept_i (accept),
    .active_o (active),
    .addr_o   (addr),
    .last_o   (last)
  );

  mhi_motion_detect i_motion (
    .cur_i    (cur_pix_i),
    .prev_i   (prev_pix_i),
    .thresh_i (thr_q),
    .moving_o (moving)
  );

  mhi_hist_update #(.HIST_MAX(HIST_MAX)) i_hist (
    .moving_i (moving),
    .old_i    (old_hist_i),
    .res_o    (res)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) thr_q <= '0;
    else if (load) thr_q <= thresh_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_q <= 1'b0;
      addr_q      <= '0;
      hist_q      <= '0;
      energy_q    <= 1'b0;
      last_q      <= 1'b0;
      done_q      <= 1'b0;
    end else begin
      out_valid_q <= accept;
      last_q      <= accept && last;
      done_q      <= last_q;
      if (accept) begin
        addr_q   <= addr;
        hist_q   <= res.hist;
        energy_q <= res.energy;
      end
    end
  end

  assign out_valid_o = out_valid_q;
  assign out_addr_o  = addr_q;
  assign new_hist_o  = hist_q;
  assign energy_o    = energy_q;
  assign done_o      = done_q;
endmodule

// File: rtl/mhi_updater_chk.sv
module mhi_updater_chk #(
  parameter int HIST_MAX = 255
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       in_valid_i,
  input logic       in_ready_o,
  input logic [7:0] old_hist_i,
  input logic       out_valid_o,
  input logic [7:0] new_hist_o,
  input logic       energy_o,
  input logic       done_o
);
  localparam logic [7:0] Ceiling = 8'(HIST_MAX);

  assert_out_after_accept_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> $past(in_valid_i && in_ready_o));

  assert_decay_by_one_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && new_hist_o != Ceiling) |->
      ((new_hist_o == $past(old_hist_i) - 8'd1) ||
       (new_hist_o == 8'd0 && $past(old_hist_i) == 8'd0)));

  assert_energy_matches_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> (energy_o == (new_hist_o != 8'd0)));

  assert_done_single_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_done_after_write_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(out_valid_o));
endmodule

bind mhi_updater mhi_updater_chk #(.HIST_MAX(HIST_MAX)) i_mhi_updater_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_valid_i  (in_valid_i),
  .in_ready_o  (in_ready_o),
  .old_hist_i  (old_hist_i),
  .out_valid_o (out_valid_o),
  .new_hist_o  (new_hist_o),
  .energy_o    (energy_o),
  .done_o      (done_o)
);

// File: tb/test_mhi_updater.sv
module test_mhi_updater;
  localparam int AW = 16;

  typedef struct packed {
    logic [AW-1:0] addr;
    logic [7:0]    hist;
    logic          energy;
    logic          last;
  } exp_t;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          start_i = 1'b0;
  logic [AW-1:0] seg_base_i = '0;
  logic [AW-1:0] seg_len_i = '0;
  logic [7:0]    thresh_i = '0;
  logic          in_valid_i = 1'b0;
  logic          in_ready_o;
  logic [7:0]    cur_pix_i = '0, prev_pix_i = '0, old_hist_i = '0;
  logic          out_valid_o;
  logic [AW-1:0] out_addr_o;
  logic [7:0]    new_hist_o;
  logic          energy_o, done_o;

  int checks = 0, errors = 0;
  exp_t exp_q[$];
  logic done_due = 1'b0;
  logic [AW-1:0] m_base, m_len, m_idx;
  logic [7:0] m_thr;
  bit finished = 0;

  always #2.5 clk_i = ~clk_i;

  mhi_updater #(.ADDR_W(AW)) i_mhi_updater (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk_i) if (rst_ni) begin
    if (done_due || done_o) chk("R8 done pulse", 32'(done_o), 32'(done_due));
    done_due = 1'b0;
    if (out_valid_o) begin
      if (exp_q.size() == 0) chk("R7 unexpected output", 32'(out_valid_o), 32'd0);
      else begin
        exp_t e;
        e = exp_q.pop_front();
        chk("R6 address", 32'(out_addr_o), 32'(e.addr));
        chk("R3/R4 history", 32'(new_hist_o), 32'(e.hist));
        chk("R5 energy", 32'(energy_o), 32'(e.energy));
        done_due = e.last;
      end
    end
  end

  task automatic start_seg(input logic [AW-1:0] b, input logic [AW-1:0] l, input logic [7:0] t);
    start_i = 1'b1; seg_base_i = b; seg_len_i = l; thresh_i = t;
    @(negedge clk_i);
    start_i = 1'b0;
    m_base = b; m_len = l; m_thr = t; m_idx = '0;
  endtask

  task automatic send(input logic [7:0] c, input logic [7:0] p, input logic [7:0] o);
    exp_t e;
    logic [7:0] d, h;
    in_valid_i = 1'b1; cur_pix_i = c; prev_pix_i = p; old_hist_i = o;
    while (!in_ready_o) @(negedge clk_i);
    d = (c >= p) ? c - p : p - c;
    if (d > m_thr) h = 8'd255;
    else if (o == 0) h = 8'd0;
    else h = o - 8'd1;
    e.addr = m_base + m_idx; e.hist = h; e.energy = (h != 0);
    e.last = (m_idx == m_len - 1);
    exp_q.push_back(e);
    m_idx = m_idx + 1'b1;
    @(negedge clk_i);
  endtask

  task automatic drain();
    in_valid_i = 1'b0;
    repeat (4) @(negedge clk_i);
    chk("R6 all results seen", 32'(exp_q.size()), 32'd0);
  endtask

  initial begin
    #20000000;
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R1 valid in reset", 32'(out_valid_o), 32'd0);
    chk("R1 ready in reset", 32'(in_ready_o), 32'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 done after reset", 32'(done_o), 32'd0);
    chk("R1 ready after reset", 32'(in_ready_o), 32'd0);

    // R2, R3, R4, R5: mixed pixels, threshold 20, with a gap
    start_seg(16'd10, 16'd7, 8'd20);
    chk("R2 ready after start", 32'(in_ready_o), 32'd1);
    send(8'd100, 8'd50, 8'd3);   // R3 motion
    send(8'd50, 8'd100, 8'd0);   // R3 reversed order
    send(8'd70, 8'd50, 8'd5);    // R3 equal to threshold -> decay 4
    in_valid_i = 1'b0; @(negedge clk_i);
    send(8'd9, 8'd9, 8'd0);      // R4 clamp at zero, R5 energy 0
    send(8'd9, 8'd9, 8'd1);      // R4 1 -> 0
    send(8'd9, 8'd9, 8'd255);    // R4 255 -> 254
    send(8'd200, 8'd179, 8'd7);  // R3 diff 21 > 20
    // R7: keep offering beats after the last one
    in_valid_i = 1'b1;
    chk("R7 ready low after last", 32'(in_ready_o), 32'd0);
    repeat (3) @(negedge clk_i);
    drain();

    // R2 mid-segment start ignored, R9 threshold change ignored
    start_seg(16'd500, 16'd3, 8'd100);
    thresh_i = 8'd0;
    send(8'd150, 8'd100, 8'd40); // R9 diff 50 under 100
    start_i = 1'b1; seg_base_i = 16'd7; seg_len_i = 16'd50;
    send(8'd0, 8'd101, 8'd40);   // R2 start ignored, R3 diff 101
    start_i = 1'b0;
    send(8'd10, 8'd10, 8'd2);
    drain();
    chk("R2 ignored start left unit idle", 32'(in_ready_o), 32'd0);

    // R2 zero-length start ignored
    start_i = 1'b1; seg_len_i = '0; seg_base_i = 16'd3;
    @(negedge clk_i); start_i = 1'b0;
    chk("R2 zero length no ready", 32'(in_ready_o), 32'd0);
    repeat (3) @(negedge clk_i);
    chk("R2 zero length no done", 32'(done_o), 32'd0);

    // long back-to-back segment
    start_seg(16'd1000, 16'd200, 8'd40);
    for (int i = 0; i < 200; i++)
      send(8'(i * 7), 8'(i * 3), 8'(i * 13));
    drain();

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule